// File: doc/BRIEF.md
# CRC-32C Zero-Run Shift Operator Builder

This unit produces the linear operator that moves a reflected CRC-32C register (polynomial 0x82F63B78) forward past a run of zero-valued bytes, without stepping through each zero. A caller pulses `start` with a byte count. The unit then builds a 32x32 matrix over GF(2) by squaring it again and again, starting from the one-bit operator. It raises `done` once the operator is held in its output bank.

Once `done` is high, the apply port takes any 32-bit CRC and returns the shifted CRC through combinational logic. A lookup port returns, one entry per request, the operator applied to a single byte placed in one of the four byte lanes. Software-style table builders can fill per-lane tables from it, and the XOR of the four lane entries for the bytes of a CRC equals the full result. Counts that are not powers of two are rounded down to the nearest power of two. A count of zero acts like a count of one.

Top module: `crc32c_zero_shift`

## Requirements
- R1: After reset, `busy`, `done` and `lut_valid` are all 0.
- R2: A `start` sampled while `busy` is 0 makes `busy` 1 and `done` 0 from the next cycle onward.
- R3: With P the largest power of two not above max(count,1) and S = 3 + log2(P) squarings, `done` rises exactly 32*S cycles after the edge that accepted `start`, plus one more cycle when S is odd. `busy` falls on the same edge that `done` rises.
- R4: While `done` is 1, `crc_out` equals `crc_in` advanced bit by bit over 8*P zero bits. Each step shifts the register right by one and XORs 0x82F63B78 when the bit shifted out was 1.
- R5: A count that is not a power of two gives the same operator as the largest power of two below it.
- R6: A count of 0 gives the same operator and latency as a count of 1.
- R7: A `start` pulse while `busy` is 1 is ignored: the build latency and the resulting operator are those of the accepted request.
- R8: A `lut_req` sampled while `done` is 1 returns `lut_valid`=1 on the next cycle. `lut_data` is then the operator applied to the 32-bit word holding `lut_index` at bits 8*`lut_lane`+7 down to 8*`lut_lane` and zeros elsewhere. A `lut_req` while `done` is 0 leaves `lut_valid` at 0.
- R9: `busy` and `done` are never both 1, and `done` stays 1 until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin building an operator for `byte_count` |
| byte_count | input | CNT_W | Number of zero bytes to advance across |
| busy | output | 1 | Operator build in progress |
| done | output | 1 | Operator ready in the output bank |
| crc_in | input | 32 | CRC to be advanced |
| crc_out | output | 32 | Advanced CRC, valid while `done` is 1 |
| lut_req | input | 1 | Request one byte-lane lookup entry |
| lut_lane | input | 2 | Byte lane of the requested entry |
| lut_index | input | 8 | Byte value of the requested entry |
| lut_valid | output | 1 | `lut_data` holds the requested entry |
| lut_data | output | 32 | Lookup entry |

## Verification
The assertions check the handshake on every cycle. They cover the exclusion of `busy` and `done`, the entry into `busy` after an accepted start, `done` holding until the next start, `done` only following a build, and `lut_valid` only following a request made while ready. The arithmetic can only be shown by the bench's scenarios. These include the match against a bit-serial reference over several counts and CRC patterns, the rounding of odd counts and the zero count, the exact latency for both odd and even squaring counts, and a start that arrives mid-build being ignored.

// File: rtl/crc32c_zero_shift.sv
module crc32c_zero_shift #(
  parameter int          CNT_W = 16,
  parameter logic [31:0] POLY  = 32'h82F63B78
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] byte_count,
  output logic             busy,
  output logic             done,
  input  logic [31:0]      crc_in,
  output logic [31:0]      crc_out,
  input  logic             lut_req,
  input  logic [1:0]       lut_lane,
  input  logic [7:0]       lut_index,
  output logic             lut_valid,
  output logic [31:0]      lut_data
);

  localparam int SQ_W = $clog2(CNT_W + 3) + 1;

  typedef logic [31:0][31:0] mat_t;

  function automatic logic [31:0] gf2_apply(input mat_t m, input logic [31:0] v);
    logic [31:0] acc;
    acc = '0;
    for (int i = 0; i < 32; i++)
      if (v[i]) acc ^= m[i];
    return acc;
  endfunction

  function automatic mat_t one_bit_op();
    mat_t m;
    m[0] = POLY;
    for (int n = 1; n < 32; n++) m[n] = 32'd1 << (n - 1);
    return m;
  endfunction

  mat_t            bank_a, bank_b;
  logic            src_b;
  logic            copying;
  logic [4:0]      row;
  logic [SQ_W-1:0] sq_left;
  logic [SQ_W-1:0] msb;
  logic [31:0]     prod;

  always_comb begin
    msb = '0;
    for (int i = 0; i < CNT_W; i++)
      if (byte_count[i]) msb = SQ_W'(i);
  end

  assign prod    = src_b ? gf2_apply(bank_b, bank_b[row]) : gf2_apply(bank_a, bank_a[row]);
  assign crc_out = gf2_apply(bank_a, crc_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_a  <= '0;
      bank_b  <= '0;
      src_b   <= 1'b0;
      copying <= 1'b0;
      row     <= '0;
      sq_left <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else if (!busy) begin
      if (start) begin
        bank_a  <= one_bit_op();
        src_b   <= 1'b0;
        row     <= '0;
        sq_left <= msb + SQ_W'(3);
        busy    <= 1'b1;
        done    <= 1'b0;
      end
    end else if (copying) begin
      bank_a  <= bank_b;
      copying <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b1;
    end else begin
      if (src_b) bank_a[row] <= prod;
      else       bank_b[row] <= prod;
      row <= row + 5'd1;
      if (row == 5'd31) begin
        src_b   <= !src_b;
        sq_left <= sq_left - SQ_W'(1);
        if (sq_left == SQ_W'(1)) begin
          if (!src_b) copying <= 1'b1;
          else begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lut_valid <= 1'b0;
      lut_data  <= '0;
    end else begin
      lut_valid <= lut_req && done;
      lut_data  <= gf2_apply(bank_a, {24'b0, lut_index} << {lut_lane, 3'b000});
    end
  end

  assert_busy_done_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  assert_done_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy && !done);

  assert_done_after_build_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));

  assert_lut_valid_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lut_valid |-> $past(lut_req && done));

endmodule

// File: tb/crc32c_zero_shift_bench.sv
module crc32c_zero_shift_bench;
  localparam logic [31:0] POLY = 32'h82F63B78;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] byte_count = '0;
  logic        busy, done;
  logic [31:0] crc_in = '0;
  logic [31:0] crc_out;
  logic        lut_req = 1'b0;
  logic [1:0]  lut_lane = '0;
  logic [7:0]  lut_index = '0;
  logic        lut_valid;
  logic [31:0] lut_data;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  crc32c_zero_shift #(.CNT_W(16)) u_crc32c_zero_shift (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_count(byte_count),
    .busy(busy), .done(done), .crc_in(crc_in), .crc_out(crc_out),
    .lut_req(lut_req), .lut_lane(lut_lane), .lut_index(lut_index),
    .lut_valid(lut_valid), .lut_data(lut_data));

  function automatic logic [31:0] ref_shift(input logic [31:0] c, input int bits);
    for (int i = 0; i < bits; i++) c = c[0] ? ((c >> 1) ^ POLY) : (c >> 1);
    return c;
  endfunction

  function automatic int pow2_floor(input int cnt);
    int p = 1;
    while (p * 2 <= cnt) p = p * 2;
    return p;
  endfunction

  function automatic int exp_latency(input int cnt);
    int p = pow2_floor(cnt);
    int s = 3;
    while (p > 1) begin p = p / 2; s++; end
    return 32 * s + (s % 2);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic build(input int cnt, input int ignore_at, input string req);
    int cycles = 0;
    @(negedge clk);
    byte_count = 16'(cnt);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(busy && !done, "R2", {30'b0, busy, done}, 32'h2);
    while (!done && cycles < 2000) begin
      @(posedge clk);
      @(negedge clk);
      cycles++;
      start = (cycles == ignore_at);
      if (start) byte_count = 16'd1;
    end
    start = 1'b0;
    chk(cycles == exp_latency(cnt) && !busy, req, 32'(cycles), 32'(exp_latency(cnt)));
  endtask

  task automatic check_apply(input int cnt, input string req);
    logic [31:0] pats [3] = '{32'h00000001, 32'hDEADBEEF, 32'h80000000};
    int bits = 8 * pow2_floor(cnt);
    foreach (pats[k]) begin
      crc_in = pats[k];
      #1;
      chk(crc_out == ref_shift(pats[k], bits), req, crc_out, ref_shift(pats[k], bits));
    end
  endtask

  task automatic t_reset();
    chk(!busy && !done && !lut_valid, "R1", {29'b0, busy, done, lut_valid}, 32'h0);
  endtask

  task automatic t_pow2(input int cnt);
    build(cnt, 0, "R3");
    check_apply(cnt, "R4");
  endtask

  task automatic t_round(input int cnt);
    build(cnt, 0, "R3");
    check_apply(cnt, "R5");
  endtask

  task automatic t_zero();
    build(0, 0, "R6");
    check_apply(1, "R6");
  endtask

  task automatic t_ignore_busy_start();
    build(4, 50, "R7");
    check_apply(4, "R7");
  endtask

  task automatic t_lut();
    logic [31:0] word = 32'h1234ABCD;
    logic [31:0] acc = '0;
    build(8, 0, "R3");
    for (int l = 0; l < 4; l++) begin
      logic [31:0] e;
      @(negedge clk);
      lut_req = 1'b1;
      lut_lane = 2'(l);
      lut_index = word[8*l +: 8];
      @(posedge clk);
      @(negedge clk);
      lut_req = 1'b0;
      e = ref_shift(32'(word[8*l +: 8]) << (8 * l), 64);
      chk(lut_valid && lut_data == e, "R8", lut_data, e);
      acc ^= lut_data;
    end
    crc_in = word;
    #1;
    chk(acc == crc_out, "R8", acc, crc_out);
    @(negedge clk);
    chk(!lut_valid, "R8", {31'b0, lut_valid}, 32'h0);
  endtask

  task automatic t_lut_when_busy();
    @(negedge clk);
    byte_count = 16'd2;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lut_req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    lut_req = 1'b0;
    chk(!lut_valid && busy, "R8", {30'b0, lut_valid, busy}, 32'h1);
    wait (done);
  endtask

  task automatic t_hold();
    repeat (20) @(negedge clk);
    chk(done && !busy, "R9", {30'b0, busy, done}, 32'h1);
    check_apply(2, "R9");
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pow2(1);
    t_pow2(2);
    t_pow2(16);
    t_pow2(128);
    t_zero();
    t_round(100);
    t_round(3);
    t_round(65535);
    t_ignore_busy_start();
    t_lut();
    t_lut_when_busy();
    t_hold();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule